// File: doc/BRIEF.md
# Coded Block Pattern Generator

This block listens to the quantized coefficient stream of one macroblock made of six 8x8 blocks and works out which blocks still carry information after quantization. For each block it keeps one flag that goes high when any coefficient of that block has a nonzero bit. Once the last of the 384 coefficients of the macroblock has been accepted, it presents the six flags as one data word with a single-cycle valid pulse. The bus logic around it then sends that word to the quantizer's return address.

A start strobe opens each macroblock. It clears the partial state and latches the intra/inter mode for the whole macroblock. In intra mode the first coefficient of every block is the DC term, which is always coded separately, so it is left out of the nonzero test. In inter mode every coefficient counts. After a pattern is emitted the block clears itself. A following macroblock can therefore stream straight in without a new start strobe, and it keeps the latched mode.

Top module: `cbp_gen`

## Requirements
- R1: While reset is asserted and after its release, before any coefficient arrives, `pat_valid` is 0 and `pat_word` is all zeros.
- R2: Bit j of `pat_word` (j = 0..5) is 1 exactly when some accepted coefficient among arrivals 64j..64j+63 of the macroblock has any nonzero bit (value bits 15:0). Data presented while `coef_valid` is 0 is not counted.
- R3: When the latched mode is intra (`intra_in` = 1), coefficient position 0 of each block is excluded from its flag. When the mode is inter (`intra_in` = 0), all 64 positions are included.
- R4: The mode is captured from `intra_in` in the cycle `mb_start` is high and held until the next `mb_start`. Changes of `intra_in` in between have no effect.
- R5: `pat_valid` is high for exactly one cycle. That cycle is the one right after the cycle in which the 384th accepted coefficient is presented. Idle cycles do not count.
- R6: Bits DATA_W-1:6 of `pat_word` are zero. `pat_word` changes only together with a `pat_valid` pulse and holds its value otherwise.
- R7: After a pattern is emitted, the flags and the coefficient count are cleared. The next 384 accepted coefficients form a new macroblock with the same latched mode, even without `mb_start`.
- R8: `mb_start` discards a partly received macroblock without a pulse and restarts the count. A coefficient presented in the same cycle as `mb_start` is coefficient 0 of the new macroblock and is judged under the mode captured in that cycle.
- R9: No `pat_valid` pulse occurs before the 384th accepted coefficient of a macroblock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| mb_start | input | 1 | Start of macroblock: clear state and capture mode |
| intra_in | input | 1 | Mode level, 1 = intra, 0 = inter; sampled with `mb_start` |
| coef_valid | input | 1 | `coef_data` carries a coefficient this cycle |
| coef_data | input | COEF_W (16) | Quantized coefficient value |
| pat_valid | output | 1 | One-cycle strobe: `pat_word` holds a new pattern |
| pat_word | output | DATA_W (32) | Bus word with the six block flags in bits 5:0 |

## Verification
The pattern is due exactly one cycle after the cycle that presents the 384th accepted coefficient. It is registered once and nothing else lies in the path. The bench drives all inputs on falling edges and reads `pat_valid` and `pat_word` on the falling edge that follows the final coefficient. It then reads them again one falling edge later to confirm the pulse has dropped. A rising-edge pulse counter confirms that no pulse appeared before the final coefficient and that exactly one appeared in total, including runs with idle gaps, mid-macroblock aborts, and a coefficient merged into the start cycle.

// File: rtl/cbp_pkg.sv
package cbp_pkg;

   // How the first coefficient of each block is treated.
   typedef enum logic [0:0] {
      DC_SKIP_INTRA = 1'b0,   // excluded from the flag when the mode is intra
      DC_ALWAYS     = 1'b1    // always counted
   } dc_mode_e;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/cbp_pos_counter.sv
module cbp_pos_counter #(
   parameter int unsigned N_BLK   = 6,
   parameter int unsigned BLK_LEN = 64
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        clr,
   input  logic                        adv,
   output logic [$clog2(N_BLK)-1:0]    blk_idx,
   output logic                        pos_first,
   output logic                        last
);
   localparam int unsigned TOTAL = N_BLK * BLK_LEN;
   localparam int unsigned CNT_W = $clog2(TOTAL);
   localparam int unsigned POS_W = $clog2(BLK_LEN);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] idx_eff;

   // A clear in the same cycle as a coefficient makes it index 0.
   assign idx_eff   = clr ? '0 : cnt_q;
   assign blk_idx   = idx_eff[CNT_W-1:POS_W];
   assign pos_first = (idx_eff[POS_W-1:0] == '0);
   assign last      = adv && (idx_eff == CNT_W'(TOTAL - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (adv) begin
         cnt_q <= last ? '0 : idx_eff + 1'b1;
      end else if (clr) begin
         cnt_q <= '0;
      end
   end

endmodule

// File: rtl/cbp_flag_accum.sv
module cbp_flag_accum
   import cbp_pkg::*;
#(
   parameter int unsigned N_BLK   = 6,
   parameter int unsigned COEF_W  = 16,
   parameter dc_mode_e    DC_MODE = DC_SKIP_INTRA
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        clr,
   input  logic                        flush,
   input  logic                        adv,
   input  logic [COEF_W-1:0]           coef,
   input  logic [$clog2(N_BLK)-1:0]    blk_idx,
   input  logic                        pos_first,
   input  logic                        intra_eff,
   output logic [N_BLK-1:0]            flags_nx
);
   localparam int unsigned BLK_W = $clog2(N_BLK);

   logic [N_BLK-1:0] flags_q;
   logic             nz;
   logic             dc_mask;

   assign nz = |coef;

   generate
      if (DC_MODE == DC_SKIP_INTRA) begin : g_dc_skip
         assign dc_mask = intra_eff & pos_first;
      end else begin : g_dc_keep
         assign dc_mask = 1'b0;
      end
   endgenerate

   generate
      for (genvar j = 0; j < N_BLK; j++) begin : g_blk
         logic hit;
         assign hit         = adv & nz & ~dc_mask & (blk_idx == BLK_W'(j));
         assign flags_nx[j] = (clr ? 1'b0 : flags_q[j]) | hit;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_q <= '0;
      end else begin
         flags_q <= flush ? '0 : flags_nx;
      end
   end

endmodule

// File: rtl/cbp_gen.sv
module cbp_gen
   import cbp_pkg::*;
#(
   parameter int unsigned N_BLK   = 6,
   parameter int unsigned BLK_LEN = 64,
   parameter int unsigned COEF_W  = 16,
   parameter int unsigned DATA_W  = 32,
   parameter dc_mode_e    DC_MODE = DC_SKIP_INTRA
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mb_start,
   input  logic              intra_in,
   input  logic              coef_valid,
   input  logic [COEF_W-1:0] coef_data,
   output logic              pat_valid,
   output logic [DATA_W-1:0] pat_word
);
   localparam int unsigned BLK_W = $clog2(N_BLK);

   generate
      if (N_BLK < 2)               begin : g_bad_nblk  $error("N_BLK must be at least 2");          end
      if (!is_pow2(BLK_LEN) || BLK_LEN < 2)
                                   begin : g_bad_len   $error("BLK_LEN must be a power of two >= 2"); end
      if (DATA_W < N_BLK)          begin : g_bad_dw    $error("DATA_W must hold N_BLK flags");   end
      if (COEF_W < 1)              begin : g_bad_cw    $error("COEF_W must be positive");        end
   endgenerate

   logic             intra_q;
   logic             intra_eff;
   logic [BLK_W-1:0] blk_idx;
   logic             pos_first;
   logic             last;
   logic [N_BLK-1:0] flags_nx;

   assign intra_eff = mb_start ? intra_in : intra_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         intra_q <= 1'b0;
      end else if (mb_start) begin
         intra_q <= intra_in;
      end
   end

   cbp_pos_counter #(
      .N_BLK   (N_BLK),
      .BLK_LEN (BLK_LEN)
   ) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (mb_start),
      .adv       (coef_valid),
      .blk_idx   (blk_idx),
      .pos_first (pos_first),
      .last      (last)
   );

   cbp_flag_accum #(
      .N_BLK   (N_BLK),
      .COEF_W  (COEF_W),
      .DC_MODE (DC_MODE)
   ) u_acc (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (mb_start),
      .flush     (last),
      .adv       (coef_valid),
      .coef      (coef_data),
      .blk_idx   (blk_idx),
      .pos_first (pos_first),
      .intra_eff (intra_eff),
      .flags_nx  (flags_nx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pat_valid <= 1'b0;
         pat_word  <= '0;
      end else begin
         pat_valid <= last;
         if (last) begin
            pat_word <= DATA_W'(flags_nx);
         end
      end
   end

endmodule

// File: rtl/cbp_gen_chk.sv
module cbp_gen_chk #(
   parameter int unsigned N_BLK   = 6,
   parameter int unsigned BLK_LEN = 64,
   parameter int unsigned DATA_W  = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mb_start,
   input logic              coef_valid,
   input logic              pat_valid,
   input logic [DATA_W-1:0] pat_word
);
   localparam int unsigned TOTAL = N_BLK * BLK_LEN;
   localparam int unsigned CW    = $clog2(TOTAL);

   // Independent arrival count kept by the checker.
   logic [CW-1:0] seen_q;
   logic          end_q;
   logic [CW-1:0] base;

   assign base = mb_start ? '0 : seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_q <= '0;
         end_q  <= 1'b0;
      end else begin
         end_q <= coef_valid && (base == CW'(TOTAL - 1));
         if (coef_valid) begin
            seen_q <= (base == CW'(TOTAL - 1)) ? '0 : base + 1'b1;
         end else if (mb_start) begin
            seen_q <= '0;
         end
      end
   end

   AST_PULSE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      pat_valid == end_q);                                             // R9
   AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      pat_valid |=> !pat_valid);                                       // R5
   AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !pat_valid |-> $stable(pat_word));                               // R6
   AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      pat_valid |-> (pat_word[DATA_W-1:N_BLK] == '0));                 // R6

endmodule

bind cbp_gen cbp_gen_chk #(
   .N_BLK   (N_BLK),
   .BLK_LEN (BLK_LEN),
   .DATA_W  (DATA_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mb_start   (mb_start),
   .coef_valid (coef_valid),
   .pat_valid  (pat_valid),
   .pat_word   (pat_word)
);

// File: tb/cbp_gen_bench.sv
`timescale 1ns/1ps
module cbp_gen_bench;
   localparam int NB    = 6;
   localparam int BL    = 64;
   localparam int TOT   = NB * BL;
   localparam int CW    = 16;
   localparam int DW    = 32;

   typedef struct packed {
      logic        intra;
      logic [5:0]  ac_mask;
      logic [5:0]  dc_mask;
      logic [5:0]  ac_pos;
      logic [15:0] ac_val;
      logic        gap;
      logic        merge;
      logic [5:0]  exp;
   } vec_t;

   localparam int NV = 7;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 6'h00, 6'h00, 6'd5,  16'h0000, 1'b0, 1'b0, 6'h00},  // R2 all zero
      '{1'b0, 6'h00, 6'h3F, 6'd5,  16'h0000, 1'b0, 1'b0, 6'h3F},  // R3 inter keeps DC
      '{1'b1, 6'h00, 6'h3F, 6'd5,  16'h0000, 1'b0, 1'b0, 6'h00},  // R3 intra drops DC
      '{1'b1, 6'h2A, 6'h15, 6'd63, 16'h8000, 1'b0, 1'b0, 6'h2A},  // R2 top bit, last pos
      '{1'b0, 6'h21, 6'h06, 6'd1,  16'h0001, 1'b1, 1'b0, 6'h27},  // R2 gaps, R5
      '{1'b1, 6'h3F, 6'h00, 6'd33, 16'h0100, 1'b0, 1'b1, 6'h3F},  // R8 merged start
      '{1'b1, 6'h01, 6'h3E, 6'd1,  16'h0002, 1'b1, 1'b1, 6'h01}   // R8 merged, intra
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          mb_start = 1'b0;
   logic          intra_in = 1'b0;
   logic          coef_valid = 1'b0;
   logic [CW-1:0] coef_data = '0;
   logic          pat_valid;
   logic [DW-1:0] pat_word;

   int checks = 0;
   int errors = 0;
   int pulses = 0;
   int cycles = 0;

   always #2.5 clk = ~clk;

   cbp_gen u_cbp_gen (
      .clk        (clk),
      .rst_n      (rst_n),
      .mb_start   (mb_start),
      .intra_in   (intra_in),
      .coef_valid (coef_valid),
      .coef_data  (coef_data),
      .pat_valid  (pat_valid),
      .pat_word   (pat_word)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (pat_valid) pulses <= pulses + 1;
   end

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   // Streams one macroblock and checks the resulting pattern.
   task automatic run_mb(input logic intra, input logic [5:0] acm, input logic [5:0] dcm,
                         input int acpos, input logic [15:0] acval, input logic gap,
                         input logic merge, input logic use_start, input int flip_at,
                         input logic [5:0] exp);
      int p0;
      p0 = pulses;
      if (use_start && !merge) begin
         @(negedge clk);
         mb_start = 1'b1; intra_in = intra; coef_valid = 1'b0; coef_data = '0;
      end
      for (int i = 0; i < TOT; i++) begin
         int b;
         int p;
         b = i / BL;
         p = i % BL;
         if (gap && (i % 5 == 2)) begin
            @(negedge clk);
            mb_start = 1'b0; coef_valid = 1'b0; coef_data = 16'hFFFF;
         end
         @(negedge clk);
         mb_start = use_start && merge && (i == 0);
         if (use_start && merge && i == 0) intra_in = intra;
         if (i == flip_at) intra_in = ~intra;
         coef_valid = 1'b1;
         coef_data  = '0;
         if (p == 0 && dcm[b]) coef_data = 16'h4000;
         if (p == acpos && acm[b]) coef_data = acval;
         if (i == TOT - 1) check("R9 no early pulse", 32'(pulses), 32'(p0));
      end
      @(negedge clk);
      mb_start = 1'b0; coef_valid = 1'b0; coef_data = '0;
      check("R5 valid after last", {31'b0, pat_valid}, 32'd1);
      check("R2 pattern word", pat_word, {26'b0, exp});
      @(negedge clk);
      check("R5 single cycle", {31'b0, pat_valid}, 32'd0);
      check("R6 word held", pat_word, {26'b0, exp});
      @(negedge clk);
      check("R5 one pulse", 32'(pulses), 32'(p0 + 1));
   endtask

   initial begin
      while (cycles < 150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: got %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int p0;
      repeat (3) @(negedge clk);
      check("R1 valid in reset", {31'b0, pat_valid}, 32'd0);
      check("R1 word in reset", pat_word, 32'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R1 valid after reset", {31'b0, pat_valid}, 32'd0);
      check("R1 word after reset", pat_word, 32'd0);

      for (int v = 0; v < NV; v++) begin
         run_mb(VECS[v].intra, VECS[v].ac_mask, VECS[v].dc_mask, int'(VECS[v].ac_pos),
                VECS[v].ac_val, VECS[v].gap, VECS[v].merge, 1'b1, -1, VECS[v].exp);
      end

      // R4: mode change mid-macroblock is ignored (intra held, DC of block 3 excluded)
      run_mb(1'b1, 6'h00, 6'h08, 5, 16'h0, 1'b0, 1'b0, 1'b1, 100, 6'h00);
      // R4: inter held while input turns intra
      run_mb(1'b0, 6'h00, 6'h08, 5, 16'h0, 1'b0, 1'b0, 1'b1, 10, 6'h08);

      // R7: continuation without start; flags cleared, mode kept (intra)
      run_mb(1'b1, 6'h3F, 6'h00, 9, 16'h0010, 1'b0, 1'b0, 1'b1, -1, 6'h3F);
      run_mb(1'b0, 6'h00, 6'h3F, 9, 16'h0000, 1'b0, 1'b0, 1'b0, -1, 6'h00);
      run_mb(1'b0, 6'h04, 6'h00, 9, 16'h0020, 1'b0, 1'b0, 1'b0, -1, 6'h04);

      // R8: abort partial macroblock with start, no pulse from the aborted part
      p0 = pulses;
      @(negedge clk);
      mb_start = 1'b1; intra_in = 1'b0; coef_valid = 1'b0;
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         mb_start = 1'b0; coef_valid = 1'b1; coef_data = 16'hFFFF;
      end
      @(negedge clk);
      coef_valid = 1'b0; coef_data = '0;
      @(negedge clk);
      check("R8 no pulse on abort", 32'(pulses), 32'(p0));
      run_mb(1'b0, 6'h00, 6'h00, 5, 16'h0, 1'b0, 1'b0, 1'b1, -1, 6'h00);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule